// File: doc/BRIEF.md
# Touch Key Suppression and Output Encoder

This block sits after the per-key touch filters of an eight-key capacitive sensing front end. Each cycle it receives, for every key, a flag saying the key is a touch candidate and a value saying how strong its signal change is. It removes unused keys. It can then keep only the strongest key, either across all keys or within each of two fixed groups. The surviving set of keys is driven onto eight key pins and one any-key detect pin.

The pins can use several formats. They can carry one line per key, active high or active low, with push-pull or open-drain drive. They can also carry a 3-bit key number in binary form. In that form the first key touched keeps the code until it is released. Every pin is modelled as a value bit and an output-enable bit.

All configuration comes from strap inputs. The straps are captured while reset is asserted and are frozen once reset is released. The block also produces a fast-detect permission flag for the upstream filters. Candidates that are present at one rising edge appear on the pins right after that edge.

Top module: `keysup_encoder`

## Requirements
- R1: The strap inputs are captured on every clock edge while `rst` is high. After `rst` falls, changes on the straps have no effect on any output. During reset no key is active, and the pins show the idle level of the captured drive format.
- R2: With `strap_sup` = 2'b00 (suppression off), every candidate key that is not masked off is reported active. Any combination of keys may be active at once. The pins reflect the candidates that were present at the previous rising edge.
- R3: With `strap_sup` = 2'b10 or 2'b11 (global), at most one key is active. It is the eligible candidate with the largest strength. When strengths are equal, the lower key index wins.
- R4: With `strap_sup` = 2'b01 (grouped), keys 0, 1, 4 and 5 form one group, and keys 2, 3, 6 and 7 form the other. Each group keeps its own strongest eligible candidate, with ties going to the lower index. The two groups do not affect each other.
- R5: A key whose bit is set in `strap_unused` is never active. It also takes no part in choosing the strongest key.
- R6: In binary format (`strap_drv` = 2'b00), pins 2..0 carry the reported key number (pin 0 is the LSB). Pins 7..3 are driven low. All nine pins are enabled, push-pull and active high. When no key is active the code is 000.
- R7: In binary format, the reported key stays reported for as long as it is active, even when other keys become active. When it releases, the code moves to the lowest-numbered key that is still active. When several keys start together from idle, the lowest-numbered one wins.
- R8: One-per-key formats: `strap_drv` = 2'b01 gives active-high push-pull, 2'b11 gives active-low push-pull, and 2'b10 gives active-low open-drain. Open-drain pins drive 0 with the enable on when active, and have the enable off (value 0) when inactive.
- R9: The detect pin is the OR of all active keys and uses the same polarity and drive as the key pins. In binary format it is the only way to tell key 0 apart from no key.
- R10: `fast_en` is high only when the fast-detect strap was captured high and suppression was captured off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| strap_sup | input | 2 | Suppression mode strap: 00 off, 01 grouped, 1x global |
| strap_drv | input | 2 | Output format, polarity and drive strap |
| strap_unused | input | 8 | Per-key mask of keys that are not fitted |
| strap_fast | input | 1 | Fast-detect request strap |
| cand | input | 8 | Per-key touch candidate flags |
| strength | input | 64 | Per-key signal strength, 8 bits per key, key 0 in the low byte |
| key_val | output | 8 | Key pin values |
| key_oe | output | 8 | Key pin output enables |
| det_val | output | 1 | Detect pin value |
| det_oe | output | 1 | Detect pin output enable |
| fast_en | output | 1 | Fast-detect permission for the upstream filters |

## Verification
The suppression logic is driven with candidate sets that span both groups and that include equal strengths. A correct global winner can then be told apart from a correct per-group winner and from a tie resolved toward the wrong index. One test places a masked key at the top strength, which separates a key that is truly ignored from one that only has its output hidden. In binary format, keys are touched one after another and then released out of order, and two keys are touched together from idle. These cases tell first-touch holding apart from lowest-index priority. Each drive format is checked with both an idle pattern and an active pattern, so inverted polarity and a wrong enable show up on separate pins. The straps are scrambled after every reset, so any sampling outside reset becomes visible.

// File: rtl/keysup_pkg.sv
package keysup_pkg;

    typedef enum logic [1:0] {
        SUP_NONE = 2'b00,
        SUP_PAIR = 2'b01,
        SUP_ALL  = 2'b10
    } sup_mode_e;

    typedef struct packed {
        logic binary;
        logic act_low;
        logic open_drain;
    } drive_cfg_t;

    function automatic sup_mode_e decode_sup(input logic [1:0] s);
        case (s)
            2'b00:   return SUP_NONE;
            2'b01:   return SUP_PAIR;
            default: return SUP_ALL;
        endcase
    endfunction

    function automatic drive_cfg_t decode_drive(input logic [1:0] s);
        drive_cfg_t c;
        case (s)
            2'b00:   c = '{binary: 1'b1, act_low: 1'b0, open_drain: 1'b0};
            2'b10:   c = '{binary: 1'b0, act_low: 1'b1, open_drain: 1'b1};
            2'b01:   c = '{binary: 1'b0, act_low: 1'b0, open_drain: 1'b0};
            default: c = '{binary: 1'b0, act_low: 1'b1, open_drain: 1'b0};
        endcase
        return c;
    endfunction

    // Group membership follows bit 1 of the key index: {0,1,4,5} and {2,3,6,7}
    function automatic logic [7:0] group_mask(input int g);
        logic [7:0] m;
        for (int k = 0; k < 8; k++) m[k] = (((k >> 1) & 1) == g);
        return m;
    endfunction

endpackage

// File: rtl/keysup_arb.sv
module keysup_arb #(
    parameter int NKEYS = 8,
    parameter int STR_W = 8
) (
    input  logic [NKEYS-1:0]       elig,
    input  logic [NKEYS*STR_W-1:0] strength,
    output logic [NKEYS-1:0]       win
);
    logic [STR_W-1:0] best;
    logic             found;

    always_comb begin
        win   = '0;
        best  = '0;
        found = 1'b0;
        for (int k = 0; k < NKEYS; k++) begin
            if (elig[k] && (!found || strength[k*STR_W +: STR_W] > best)) begin
                win    = '0;
                win[k] = 1'b1;
                best   = strength[k*STR_W +: STR_W];
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/keysup_hold.sv
module keysup_hold #(
    parameter int NKEYS  = 8,
    parameter int CODE_W = $clog2(NKEYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NKEYS-1:0]  act_d,
    output logic [CODE_W-1:0] code_q,
    output logic              vld_q
);
    logic [CODE_W-1:0] code_d;
    logic              vld_d;

    always_comb begin
        code_d = code_q;
        vld_d  = vld_q;
        if (!(vld_q && act_d[code_q])) begin
            vld_d  = |act_d;
            code_d = '0;
            for (int k = NKEYS - 1; k >= 0; k--) begin
                if (act_d[k]) code_d = CODE_W'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            code_q <= code_d;
            vld_q  <= vld_d;
        end
    end

    // R7: a reported key that stays active keeps the code
    assert_hold_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (vld_q && act_d[code_q]) |=> (vld_q && code_q == $past(code_q)));
endmodule

// File: rtl/keysup_pins.sv
module keysup_pins
    import keysup_pkg::*;
#(
    parameter int NKEYS  = 8,
    parameter int CODE_W = $clog2(NKEYS)
) (
    input  drive_cfg_t        cfg,
    input  logic [NKEYS-1:0]  act,
    input  logic [CODE_W-1:0] code,
    input  logic              vld,
    output logic [NKEYS-1:0]  key_val,
    output logic [NKEYS-1:0]  key_oe,
    output logic              det_val,
    output logic              det_oe
);
    logic any;
    assign any = |act;

    always_comb begin
        if (cfg.binary) begin
            key_val             = '0;
            key_val[CODE_W-1:0] = vld ? code : '0;
            key_oe              = '1;
            det_val             = vld;
            det_oe              = 1'b1;
        end else if (cfg.open_drain) begin
            key_val = '0;
            key_oe  = act;
            det_val = 1'b0;
            det_oe  = any;
        end else begin
            key_val = cfg.act_low ? ~act : act;
            key_oe  = '1;
            det_val = cfg.act_low ? ~any : any;
            det_oe  = 1'b1;
        end
    end
endmodule

// File: rtl/keysup_encoder.sv
module keysup_encoder
    import keysup_pkg::*;
#(
    parameter int NKEYS = 8,
    parameter int STR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             strap_sup,
    input  logic [1:0]             strap_drv,
    input  logic [NKEYS-1:0]       strap_unused,
    input  logic                   strap_fast,
    input  logic [NKEYS-1:0]       cand,
    input  logic [NKEYS*STR_W-1:0] strength,
    output logic [NKEYS-1:0]       key_val,
    output logic [NKEYS-1:0]       key_oe,
    output logic                   det_val,
    output logic                   det_oe,
    output logic                   fast_en
);
    localparam int CODE_W = $clog2(NKEYS);
    localparam int NGRP   = 2;

    sup_mode_e        sup_q;
    drive_cfg_t       drv_q;
    logic [NKEYS-1:0] unused_q;
    logic             fast_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sup_q    <= decode_sup(strap_sup);
            drv_q    <= decode_drive(strap_drv);
            unused_q <= strap_unused;
            fast_q   <= strap_fast;
        end
    end

    logic [NKEYS-1:0] elig, win_all, win_grp, act_d, act_q;
    logic [NKEYS-1:0] grp_win [NGRP];

    assign elig = cand & ~unused_q;

    keysup_arb #(.NKEYS(NKEYS), .STR_W(STR_W)) u_arb_all (
        .elig(elig), .strength(strength), .win(win_all));

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [NKEYS-1:0] GMASK = NKEYS'(group_mask(g));
        keysup_arb #(.NKEYS(NKEYS), .STR_W(STR_W)) u_arb (
            .elig(elig & GMASK), .strength(strength), .win(grp_win[g]));
    end

    always_comb begin
        win_grp = '0;
        for (int g = 0; g < NGRP; g++) win_grp = win_grp | grp_win[g];
        case (sup_q)
            SUP_NONE: act_d = elig;
            SUP_PAIR: act_d = win_grp;
            default:  act_d = win_all;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= act_d;
    end

    logic [CODE_W-1:0] code_q;
    logic              vld_q;

    keysup_hold #(.NKEYS(NKEYS), .CODE_W(CODE_W)) u_hold (
        .clk(clk), .rst(rst), .act_d(act_d), .code_q(code_q), .vld_q(vld_q));

    keysup_pins #(.NKEYS(NKEYS), .CODE_W(CODE_W)) u_pins (
        .cfg(drv_q), .act(act_q), .code(code_q), .vld(vld_q),
        .key_val(key_val), .key_oe(key_oe), .det_val(det_val), .det_oe(det_oe));

    assign fast_en = fast_q && (sup_q == SUP_NONE);

    assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(sup_q) && $stable(drv_q) && $stable(unused_q) && $stable(fast_q)));

    assert_global_single_R3: assert property (@(posedge clk) disable iff (rst)
        (sup_q == SUP_ALL) |-> $onehot0(act_q));

    assert_group_single_R4: assert property (@(posedge clk) disable iff (rst)
        (sup_q == SUP_PAIR) |-> ($countones(act_q & NKEYS'(group_mask(0))) <= 1 &&
                                 $countones(act_q & NKEYS'(group_mask(1))) <= 1));

    assert_unused_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (act_q & unused_q) == '0);

    assert_bin_upper_R6: assert property (@(posedge clk) disable iff (rst)
        drv_q.binary |-> (key_val[NKEYS-1:CODE_W] == '0 && &key_oe && det_oe));

    assert_detect_or_R9: assert property (@(posedge clk) disable iff (rst)
        (!drv_q.binary && !drv_q.act_low && !drv_q.open_drain) |-> (det_val == |key_val));

    assert_fast_gate_R10: assert property (@(posedge clk) disable iff (rst)
        fast_en |-> (sup_q == SUP_NONE));
endmodule

// File: tb/tb_keysup_encoder.sv
`timescale 1ns/100ps
module tb_keysup_encoder;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] strap_sup = '0, strap_drv = 2'b01;
    logic [N-1:0] strap_unused = '0;
    logic strap_fast = 1'b0;
    logic [N-1:0] cand = '0;
    logic [N*8-1:0] strength = '0;
    logic [N-1:0] key_val, key_oe;
    logic det_val, det_oe, fast_en;

    always #2 clk = ~clk;

    keysup_encoder dut (.*);

    typedef struct packed {
        logic [N-1:0] val;
        logic [N-1:0] oe;
        logic dv, doe, fe;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int checks = 0, errors = 0;
    bit done = 0;

    logic [1:0] m_sup, m_drv;
    logic [N-1:0] m_unused;
    logic m_fast;
    logic [2:0] m_code;
    logic m_vld;
    logic [7:0] s [N];

    function automatic logic [N-1:0] strongest(input logic [N-1:0] e);
        logic [N-1:0] w = '0;
        logic [7:0] b = '0;
        bit f = 0;
        for (int k = 0; k < N; k++)
            if (e[k] && (!f || s[k] > b)) begin w = '0; w[k] = 1'b1; b = s[k]; f = 1; end
        return w;
    endfunction

    function automatic exp_t pins(input logic [N-1:0] l);
        exp_t x;
        x.fe = m_fast && (m_sup == 2'b00);
        if (m_drv == 2'b00) begin
            x.val = {5'b0, m_vld ? m_code : 3'b0}; x.oe = '1; x.dv = m_vld; x.doe = 1'b1;
        end else if (m_drv == 2'b10) begin
            x.val = '0; x.oe = l; x.dv = 1'b0; x.doe = |l;
        end else if (m_drv == 2'b11) begin
            x.val = ~l; x.oe = '1; x.dv = ~|l; x.doe = 1'b1;
        end else begin
            x.val = l; x.oe = '1; x.dv = |l; x.doe = 1'b1;
        end
        return x;
    endfunction

    task automatic do_reset(input logic [1:0] sp, input logic [1:0] dr,
                            input logic [N-1:0] un, input logic fs);
        @(negedge clk);
        rst = 1'b1; strap_sup = sp; strap_drv = dr; strap_unused = un; strap_fast = fs;
        cand = '0;
        m_sup = sp; m_drv = dr; m_unused = un; m_fast = fs; m_code = '0; m_vld = 0;
        @(posedge clk); @(posedge clk); #0.5;
        q_exp.push_back(pins('0)); q_tag.push_back("R1 reset state");
        @(negedge clk);
        rst = 1'b0;
        // scramble straps after reset: must have no effect (R1)
        strap_sup = ~sp; strap_drv = ~dr; strap_unused = ~un; strap_fast = ~fs;
    endtask

    task automatic step(input logic [N-1:0] c, input string tag);
        logic [N-1:0] e, a;
        @(negedge clk);
        cand = c;
        for (int k = 0; k < N; k++) strength[k*8 +: 8] = s[k];
        e = c & ~m_unused;
        if (m_sup == 2'b00) a = e;
        else if (m_sup == 2'b01) a = strongest(e & 8'h33) | strongest(e & 8'hCC);
        else a = strongest(e);
        if (!(m_vld && a[m_code])) begin
            m_vld = |a; m_code = '0;
            for (int k = N - 1; k >= 0; k--) if (a[k]) m_code = 3'(k);
        end
        @(posedge clk); #0.5;
        q_exp.push_back(pins(a)); q_tag.push_back(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk); #1;
            if (q_exp.size() > 0) begin
                exp_t x;
                string t;
                x = q_exp.pop_front(); t = q_tag.pop_front();
                checks++;
                if ({key_val, key_oe, det_val, det_oe, fast_en} !== {x.val, x.oe, x.dv, x.doe, x.fe}) begin
                    errors++;
                    $display("FAIL %s: got val=%h oe=%h det=%b/%b fast=%b expected val=%h oe=%h det=%b/%b fast=%b",
                             t, key_val, key_oe, det_val, det_oe, fast_en,
                             x.val, x.oe, x.dv, x.doe, x.fe);
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < N; k++) s[k] = 8'(10 + k);
        // suppression off, active-high push-pull, fast requested
        do_reset(2'b00, 2'b01, 8'h00, 1'b1);
        step(8'hA5, "R2 all candidates pass, R10 fast allowed");
        step(8'hFF, "R2 all keys, R9 detect high");
        step(8'h00, "R2 release, R9 detect low");

        // global suppression, key 4 unused
        do_reset(2'b10, 2'b01, 8'h10, 1'b1);
        s[4] = 8'd200; s[2] = 8'd90; s[6] = 8'd50;
        step(8'h5F, "R5 unused strongest key ignored, R3 global winner, R10 fast blocked");
        s[1] = 8'd90;
        step(8'h06, "R3 tie goes to lower index");
        step(8'h10, "R5 unused key alone gives nothing");

        // grouped suppression
        do_reset(2'b01, 2'b01, 8'h00, 1'b0);
        s[0] = 8'd5; s[1] = 8'd40; s[4] = 8'd30; s[5] = 8'd20;
        s[2] = 8'd15; s[3] = 8'd16; s[6] = 8'd70; s[7] = 8'd1;
        step(8'hFF, "R4 one winner per group");
        step(8'h33, "R4 group A only");
        step(8'h8C, "R4 group B independent");

        // binary format, suppression off
        do_reset(2'b00, 2'b00, 8'h00, 1'b0);
        step(8'h20, "R6 single key code");
        step(8'h24, "R7 later key hidden");
        step(8'h04, "R7 switch to remaining key");
        step(8'h00, "R6 idle code zero, R9 detect low");
        step(8'h48, "R7 simultaneous lowest wins");
        step(8'h40, "R7 release moves to key 6");
        step(8'h01, "R9 key 0 told apart by detect");

        // binary with global suppression (reserved code 11)
        do_reset(2'b11, 2'b00, 8'h00, 1'b0);
        step(8'hC0, "R3 reserved code acts global, R6 code");

        // open-drain active low
        do_reset(2'b00, 2'b10, 8'h00, 1'b0);
        step(8'h81, "R8 open-drain active, R9 detect pulls low");
        step(8'h00, "R8 open-drain released");

        // active-low push-pull
        do_reset(2'b00, 2'b11, 8'h02, 1'b0);
        step(8'h0E, "R8 active-low push-pull, R5 mask");
        step(8'h00, "R8 active-low idle, R9");

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule